// File: doc/BRIEF.md
# Bandwidth-Limited Squash Walker for a Multi-Thread Reorder Buffer

This block carries out the squash step of a reorder buffer that is shared by several hardware threads. A squash request names one thread and a boundary sequence number. Every entry of that thread that is younger than the boundary must be killed. The block does not free those entries. It walks the thread's ring from the youngest entry toward the oldest and pulses a one-cycle mark strobe for each entry it kills. The owner of the entry storage takes that strobe to set both the entry's squashed flag and its commit-ready flag, so the dead entries drain out through the normal commit path.

The walk is limited in bandwidth: no more than `SQW` entries are marked in one cycle. The walk ends when it reaches an entry whose sequence number is not above the boundary, or after it has marked the thread's oldest entry. Each thread has its own walk pointer, latched boundary and done flag. While several threads are walking, one thread advances per cycle, and the lowest-numbered thread goes first. When the thread's youngest entry is marked, the block raises a tail-recompute strobe.

Each thread keeps its entries in a ring of `DEPTH` slots (`DEPTH` a power of two). The storage provides the physical slot of the oldest entry (`head_i`), the number of live entries (`cnt_i`) and the sequence number held in every slot (`seq_i`). The entry at age offset j (0 = oldest) sits in slot `(head + j) mod DEPTH`.

Top module: `sq_walker`

## Requirements
- R1: After reset every bit of `done_o` is 1, `mark_o` is all zero and `tail_upd_o` is 0.
- R2: A request for a thread whose `cnt_i` is 0 produces no mark and leaves that thread's `done_o` bit at 1.
- R3: A request for a thread with `cnt_i` > 0 clears that thread's `done_o` bit at the next clock edge and latches the boundary. In the cycle after that edge, marking starts at the thread's youngest entry (age offset `cnt-1`).
- R4: In any cycle `mark_o` has at most `SQW` bits set. Those bits are consecutive age offsets of one thread, going from younger to older.
- R5: An entry is marked only when its sequence number is strictly greater than the latched boundary (unsigned compare). When the walk meets an entry that is less than or equal to the boundary, that entry is not marked and the thread's done bit is 1 from the next edge on. This holds when the meeting falls in the middle of a batch and also when it falls right after a full batch.
- R6: Once the thread's oldest entry (age offset 0) has been marked, the walk ends and the done bit is 1 from the next edge on.
- R7: During one walk each entry is marked in exactly one cycle, and the walk takes max(1, ceil(m/SQW)) cycles, where m is the number of entries it kills.
- R8: `tail_upd_o` is 1 in exactly those cycles in which the walked thread's youngest entry is marked.
- R9: In each cycle, only the lowest-numbered thread whose done bit is 0 advances. The other walking threads keep their pointer and boundary and carry on once it has finished.
- R10: A new request for a thread that is still walking restarts that thread from its youngest entry with the new boundary.
- R11: A thread whose done bit is 1 never has any `mark_o` bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Squash request strobe |
| req_tid_i | input | TID_W | Thread named by the request |
| req_bnd_i | input | SEQ_W | Boundary sequence number; entries above it are killed |
| seq_i | input | NTHR*DEPTH*SEQ_W | Sequence number of each slot, thread-major then slot |
| head_i | input | NTHR*IDX_W | Slot of each thread's oldest entry |
| cnt_i | input | NTHR*(IDX_W+1) | Live entry count of each thread |
| mark_o | output | NTHR*DEPTH | One-cycle strobe per slot: set squashed and commit-ready |
| tail_upd_o | output | 1 | Youngest entry of the walked thread marked; recompute tail |
| done_o | output | NTHR | Per-thread walk finished flag |

## Verification
The bench sweeps every head slot, every fill level from empty to full, and boundaries from below the oldest entry to above the youngest. Both parities of the kill count are covered, so the walk can stop in the middle of a batch or just after a full batch. A design that skips the check that follows a batch would keep walking for an extra idle cycle. A design that compares with "greater or equal" would kill the entry equal to the boundary. A design that ignores the head stop would wrap around into dead slots. Separate scenarios cover a lower thread pre-empting a higher one in the middle of its walk, where an arbiter without priority, or one that loses state, would mark the wrong slots or repeat them. They also cover a restart with a new boundary while a walk is in flight.

// File: rtl/sq_pkg.sv
`timescale 1ns/1ps
package sq_pkg;
  localparam int unsigned NTHR_DEF  = 2;
  localparam int unsigned DEPTH_DEF = 8;
  localparam int unsigned SEQ_W_DEF = 8;
  localparam int unsigned SQW_DEF   = 2;

  function automatic int unsigned tid_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/sq_pick.sv
`timescale 1ns/1ps
// Lowest-index grant among requesters
module sq_pick #(
  parameter int unsigned N = 2
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  always_comb begin
    logic found;
    found = 1'b0;
    gnt_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !found) begin
        gnt_o[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sq_batch.sv
`timescale 1ns/1ps
// One cycle of walk for the selected thread: up to SQW entries, youngest first
module sq_batch #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned SEQ_W = 8,
  parameter int unsigned SQW   = 2,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH*SEQ_W-1:0] seq_i,
  input  logic [IDX_W-1:0]       head_i,
  input  logic [IDX_W-1:0]       pos_i,
  input  logic [SEQ_W-1:0]       bnd_i,
  output logic [DEPTH-1:0]       mark_o,
  output logic [IDX_W-1:0]       pos_nxt_o,
  output logic                   fin_o
);
  always_comb begin
    logic             go;
    logic [IDX_W:0]   n;
    logic [IDX_W-1:0] off;
    logic [IDX_W-1:0] slot;
    mark_o = '0;
    go     = 1'b1;
    n      = '0;
    fin_o  = 1'b0;
    for (int k = 0; k < SQW; k++) begin
      off  = pos_i - IDX_W'(n);
      slot = head_i + off;
      if (go) begin
        if (seq_i[slot*SEQ_W +: SEQ_W] > bnd_i) begin
          mark_o[slot] = 1'b1;
          n            = n + 1'b1;
          if (off == '0) begin
            fin_o = 1'b1;   // oldest entry reached
            go    = 1'b0;
          end
        end else begin
          go = 1'b0;
        end
      end
    end
    pos_nxt_o = pos_i - IDX_W'(n);
    slot      = head_i + pos_nxt_o;
    if (!fin_o && !(seq_i[slot*SEQ_W +: SEQ_W] > bnd_i))
      fin_o = 1'b1;         // pointer rests on a survivor
  end
endmodule

// File: rtl/sq_walker.sv
`timescale 1ns/1ps
module sq_walker #(
  parameter int unsigned NTHR  = sq_pkg::NTHR_DEF,
  parameter int unsigned DEPTH = sq_pkg::DEPTH_DEF,
  parameter int unsigned SEQ_W = sq_pkg::SEQ_W_DEF,
  parameter int unsigned SQW   = sq_pkg::SQW_DEF,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = IDX_W + 1,
  localparam int unsigned TID_W = sq_pkg::tid_width(NTHR)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_i,
  input  logic [TID_W-1:0]             req_tid_i,
  input  logic [SEQ_W-1:0]             req_bnd_i,
  input  logic [NTHR*DEPTH*SEQ_W-1:0]  seq_i,
  input  logic [NTHR*IDX_W-1:0]        head_i,
  input  logic [NTHR*CNT_W-1:0]        cnt_i,
  output logic [NTHR*DEPTH-1:0]        mark_o,
  output logic                         tail_upd_o,
  output logic [NTHR-1:0]              done_o
);
  logic [NTHR-1:0]  done_q;
  logic [IDX_W-1:0] pos_q [NTHR];
  logic [SEQ_W-1:0] bnd_q [NTHR];
  logic [NTHR-1:0]  gnt;
  logic [NTHR-1:0]  mark_any;
  logic [TID_W-1:0] sel;
  logic [DEPTH*SEQ_W-1:0] sel_seq;
  logic [IDX_W-1:0] sel_head, sel_pos, pos_nxt, ysl;
  logic [CNT_W-1:0] sel_cnt, req_cnt;
  logic [SEQ_W-1:0] sel_bnd;
  logic [DEPTH-1:0] bmark;
  logic             fin;

  sq_pick #(.N(NTHR)) u_pick (.req_i(~done_q), .gnt_o(gnt));

  always_comb begin
    sel = '0;
    for (int t = 0; t < NTHR; t++)
      if (gnt[t]) sel = TID_W'(t);
  end

  assign sel_seq  = seq_i[sel*DEPTH*SEQ_W +: DEPTH*SEQ_W];
  assign sel_head = head_i[sel*IDX_W +: IDX_W];
  assign sel_cnt  = cnt_i[sel*CNT_W +: CNT_W];
  assign sel_pos  = pos_q[sel];
  assign sel_bnd  = bnd_q[sel];
  assign req_cnt  = cnt_i[req_tid_i*CNT_W +: CNT_W];

  sq_batch #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .SQW(SQW)) u_batch (
    .seq_i(sel_seq), .head_i(sel_head), .pos_i(sel_pos), .bnd_i(sel_bnd),
    .mark_o(bmark), .pos_nxt_o(pos_nxt), .fin_o(fin)
  );

  assign ysl        = sel_head + IDX_W'(sel_cnt - 1'b1);
  assign tail_upd_o = (|gnt) && bmark[ysl];
  assign done_o     = done_q;

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    logic hit;
    assign hit = req_i && (req_tid_i == TID_W'(t));
    assign mark_o[t*DEPTH +: DEPTH] = gnt[t] ? bmark : '0;
    assign mark_any[t] = |mark_o[t*DEPTH +: DEPTH];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        done_q[t] <= 1'b1;
        pos_q[t]  <= '0;
        bnd_q[t]  <= '0;
      end else if (hit) begin
        if (cnt_i[t*CNT_W +: CNT_W] == '0) begin
          done_q[t] <= 1'b1;
        end else begin
          done_q[t] <= 1'b0;
          pos_q[t]  <= IDX_W'(cnt_i[t*CNT_W +: CNT_W] - 1'b1);
          bnd_q[t]  <= req_bnd_i;
        end
      end else if (gnt[t]) begin
        pos_q[t] <= pos_nxt;
        if (fin) done_q[t] <= 1'b1;
      end
    end

    AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_q[t] |-> !mark_any[t]); // R11
  end

  AST_ONE_THR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(mark_any)); // R9
  AST_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(mark_o) <= SQW); // R4
  AST_REQ_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && req_cnt != '0) |=> !done_o[$past(req_tid_i)]); // R3
  AST_EMPTY_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && req_cnt == '0) |=> done_o[$past(req_tid_i)]); // R2
  AST_TAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tail_upd_o |-> (mark_o != '0)); // R8
endmodule

// File: tb/sim_sq_walker.sv
`timescale 1ns/1ps
module sim_sq_walker;
  localparam int NT = 2, D = 8, SW = 8, W = 2, IW = 3, CW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0;
  logic [0:0] req_tid = '0;
  logic [SW-1:0] req_bnd = '0;
  logic [NT*D*SW-1:0] seq = '0;
  logic [NT*IW-1:0] head = '0;
  logic [NT*CW-1:0] cnt = '0;
  logic [NT*D-1:0] mark;
  logic tail_upd;
  logic [NT-1:0] done;
  int checks = 0, bad = 0;

  always #5 clk = ~clk;

  sq_walker u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_tid_i(req_tid), .req_bnd_i(req_bnd),
    .seq_i(seq), .head_i(head), .cnt_i(cnt), .mark_o(mark), .tail_upd_o(tail_upd), .done_o(done)
  );

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  // entry at age offset j holds 10+2j
  task automatic set_thr(input int t, input int h, input int c);
    head[t*IW +: IW] = IW'(h);
    cnt[t*CW +: CW]  = CW'(c);
    for (int j = 0; j < D; j++)
      seq[(t*D + ((h + j) % D))*SW +: SW] = SW'(10 + 2*j);
  endtask

  function automatic logic [NT*D-1:0] exp_mark(input int t, input int h, input int c,
                                               input int i0, input int m);
    logic [NT*D-1:0] v = '0;
    for (int k = 0; k < W; k++) begin
      int i = i0 + k;
      if (i < m) v[t*D + ((h + c - 1 - i) % D)] = 1'b1;
    end
    return v;
  endfunction

  // request at current negedge, then check the whole walk
  task automatic run_case(input int t, input int h, input int c, input int b);
    int m = 0, cyc;
    for (int j = 0; j < c; j++) if (10 + 2*j > b) m++;
    cyc = (m + W - 1) / W;
    if (cyc == 0) cyc = 1;
    req_tid = 1'(t); req_bnd = SW'(b); req = 1'b1;
    @(negedge clk); req = 1'b0;
    if (c == 0) begin
      chk(mark == '0 && done == 2'b11, "R2 empty request", {mark, done}, {16'h0, 2'b11});
      return;
    end
    for (int k = 0; k < cyc; k++) begin
      logic [NT*D-1:0] e = exp_mark(t, h, c, k*W, m);
      chk(mark == e, "R4/R5/R7 marks", mark, e);                       // R7 each entry once
      chk(tail_upd == (k == 0 && m > 0), "R8 tail update", tail_upd, (k == 0 && m > 0));
      chk(done[t] == 1'b0, (k == 0) ? "R3 done cleared" : "R7 walk length", done[t], 0);
      @(negedge clk);
    end
    chk(done[t] == 1'b1, (m == c) ? "R6 stop at oldest" : "R5 stop at boundary", done[t], 1);
    chk(mark == '0, "R11 quiet when done", mark, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk(done == 2'b11 && mark == '0 && !tail_upd, "R1 reset state", {mark, tail_upd, done}, 3);
    rst_n = 1'b1;
    @(negedge clk);

    // sweep head, fill level and boundary on thread 0
    for (int h = 0; h < D; h++)
      for (int c = 0; c <= D; c++)
        for (int b = 8; b <= 28; b++) begin
          set_thr(0, h, c);
          set_thr(1, 0, 0);
          run_case(0, h, c, b);
        end

    // thread 1 on its own, odd head
    set_thr(0, 0, 0); set_thr(1, 5, 7);
    run_case(1, 5, 7, 13);

    // R9: thread 0 pre-empts thread 1 mid-walk
    set_thr(0, 0, 8); set_thr(1, 0, 8);
    req_tid = 1'b1; req_bnd = '0; req = 1'b1;
    @(negedge clk);
    req_tid = 1'b0;
    for (int k = 0; k < 8; k++) begin
      int t, i;
      logic [NT*D-1:0] e;
      if (k == 1) req = 1'b0;
      if (k == 0) begin t = 1; i = 0; end
      else if (k <= 4) begin t = 0; i = (k - 1) * W; end
      else begin t = 1; i = (k - 4) * W; end
      e = exp_mark(t, 0, 8, i, 8);
      if (k >= 1) begin
        chk(mark == e, "R9 arbitration marks", mark, e);
        chk(tail_upd == (k == 1), "R9 tail on pre-empt", tail_upd, (k == 1));
      end else begin
        chk(mark == e, "R9 first thread marks", mark, e);
      end
      @(negedge clk);
    end
    chk(done == 2'b11, "R9 both done", done, 2'b11);

    // R10: restart with a new boundary mid-walk
    set_thr(1, 0, 0); set_thr(0, 3, 8);
    req_tid = 1'b0; req_bnd = '0; req = 1'b1;
    @(negedge clk); req = 1'b0;
    chk(mark == exp_mark(0, 3, 8, 0, 8), "R10 first walk", mark, exp_mark(0, 3, 8, 0, 8));
    run_case(0, 3, 8, 13); // R10 restarts at youngest

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule